// File: doc/BRIEF.md
# I/O MMU Context Control and Fault-Status Register Bank

This block holds the control and fault state of a small I/O translation unit that serves four translation contexts. Software reaches it through a simple 32-bit register read/write port. Each context has a 0x40-byte window placed at `context × 0x40`. The same bank also appears at a second base 0x800 higher, and both views reach identical state. From each context's control word the block drives a translation-enable line and an interrupt-enable line. It also issues a one-cycle TLB-invalidate strobe to the translation logic and holds a busy indication until that logic returns a done pulse.

The translation logic reports faults on a side channel: a context number, a fault kind, an error code, a table level and the faulting address. The bank captures the first fault of each context and keeps it until software acknowledges it. Software acknowledges a fault by writing zero to the status word. That write clears the flags and also wipes the captured address, so software reads the address first. One interrupt output combines the pending faults of every context whose interrupt enable is set.

Top module: `iommu_ctx_bank`

## Requirements
- R1: After reset every control, status and fault-address word reads 0, and `ctx_en_o`, `irq_en_o`, `flush_o`, `irq_o` and `rdata_o` are 0.
- R2: Within a context window the control word sits at offset 0x00. Only bits 0 (translate enable), 2 (interrupt enable), 3, 5:4, 16 and 17 are stored, and every other bit reads 0. `ctx_en_o[c]` follows bit 0 and `irq_en_o[c]` follows bit 2 from the cycle after the write.
- R3: Writing a control word with bit 1 set raises `flush_o[c]` for exactly one cycle after the write edge. Control bit 1 then reads 1 until `flush_done_i[c]` is seen, and writing 0 to bit 1 does not cancel it.
- R4: Context c decodes at byte address c×0x40. An address with bit 11 set (base + 0x800) reaches the same registers.
- R5: A fault report captures its data into the status word at offset 0x20 and the address word at offset 0x30 of context `flt_ctx_i`. The status word holds TF at bit 0, PF at bit 1, ABORT at bit 2, multiple-hit at bit 4, the code at bits 10:8 and the level at bits 13:12. `flt_kind_i` bits 0..3 map to TF, PF, ABORT and multiple-hit, and a kind of 0 is not captured.
- R6: While a context has any fault flag set, further reports for that context are dropped, so the first status and address are kept.
- R7: Writing 0 to the status word clears the flags, code, level and fault address. Writing a nonzero value to the status word has no effect.
- R8: `irq_o` is high while some context has its interrupt enable set and at least one fault flag set.
- R9: Reads of unmapped offsets or of context indices beyond the last context return 0, and writes to them change nothing.
- R10: Read data appears on `rdata_o` in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| flt_valid_i | input | 1 | Fault report strobe |
| flt_ctx_i | input | 2 | Context of the fault |
| flt_kind_i | input | 4 | Fault kind: TF, PF, ABORT, multiple-hit |
| flt_code_i | input | 3 | Error code |
| flt_lvl_i | input | 2 | Table level of the fault |
| flt_addr_i | input | 32 | Faulting address |
| flush_done_i | input | 4 | Invalidate-finished pulse per context |
| ctx_en_o | output | 4 | Translate enable per context |
| irq_en_o | output | 4 | Interrupt enable per context |
| flush_o | output | 4 | One-cycle invalidate strobe per context |
| irq_o | output | 1 | Combined fault interrupt |

## Verification
A register write takes effect at the clock edge that accepts it. Control outputs, `flush_o` and the busy bit all change at that same edge. A fault report is captured at its edge, and `irq_o` follows in that same cycle because it is combinational from registers. Read data lags the request by one edge. The bench drives on the falling edge and samples on the next falling edge, so every result is checked in the first cycle it is due. The strobe is checked again one cycle later to prove it is only one cycle long.

// File: rtl/iommu_bank_pkg.sv
package iommu_bank_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_STAT, SEL_EADDR} reg_sel_e;

  localparam int unsigned OFF_CTRL  = 'h00;
  localparam int unsigned OFF_STAT  = 'h20;
  localparam int unsigned OFF_EADDR = 'h30;

  // stored control bits: en, inten, bit3, 5:4, 16, 17 (bit1 is the busy flag)
  localparam logic [31:0] CTRL_WMASK = 32'h0003_003D;
  localparam int unsigned CTRL_EN_B    = 0;
  localparam int unsigned CTRL_FLUSH_B = 1;
  localparam int unsigned CTRL_INTEN_B = 2;
endpackage

// File: rtl/iommu_bank_decode.sv
module iommu_bank_decode
  import iommu_bank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned NUM_CTX    = 4,
  parameter int unsigned CTX_STRIDE = 64,
  parameter logic [ADDR_W-1:0] ALIAS_OFF = 12'h800,
  localparam int unsigned CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int unsigned OFF_W = $clog2(CTX_STRIDE)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [CTX_W-1:0]  ctx_o
);
  logic [ADDR_W-1:0] local_a;
  logic [ADDR_W-1:0] idx;
  logic [OFF_W-1:0]  off;

  assign local_a = addr_i & ~ALIAS_OFF;
  assign idx     = local_a >> OFF_W;
  assign off     = local_a[OFF_W-1:0];
  assign ctx_o   = idx[CTX_W-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if (idx < ADDR_W'(NUM_CTX)) begin
      if (off == OFF_W'(OFF_CTRL))       sel_o = SEL_CTRL;
      else if (off == OFF_W'(OFF_STAT))  sel_o = SEL_STAT;
      else if (off == OFF_W'(OFF_EADDR)) sel_o = SEL_EADDR;
    end
  end
endmodule

// File: rtl/iommu_ctx_slot.sv
module iommu_ctx_slot
  import iommu_bank_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_we_i,
  input  logic        clr_i,
  input  logic [31:0] wdata_i,
  input  logic        flt_cap_i,
  input  logic [3:0]  flt_kind_i,
  input  logic [2:0]  flt_code_i,
  input  logic [1:0]  flt_lvl_i,
  input  logic [31:0] flt_addr_i,
  input  logic        flush_done_i,
  output logic [31:0] ctrl_o,
  output logic [31:0] stat_o,
  output logic [31:0] eaddr_o,
  output logic        en_o,
  output logic        inten_o,
  output logic        flush_o,
  output logic        busy_o,
  output logic        fault_o
);
  logic [31:0] ctrl_q;
  logic        busy_q, flush_q;
  logic [3:0]  flags_q;
  logic [2:0]  code_q;
  logic [1:0]  lvl_q;
  logic [31:0] eaddr_q;
  logic        start, take;

  assign start = ctrl_we_i & wdata_i[CTRL_FLUSH_B];
  // a clear in the same cycle frees the slot for the new report
  assign take  = flt_cap_i & (|flt_kind_i) & ((flags_q == 4'd0) | clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      busy_q  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= start;
      if (ctrl_we_i) ctrl_q <= wdata_i & CTRL_WMASK;
      if (start) busy_q <= 1'b1;
      else if (flush_done_i) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      code_q  <= '0;
      lvl_q   <= '0;
      eaddr_q <= '0;
    end else if (take) begin
      flags_q <= flt_kind_i;
      code_q  <= flt_code_i;
      lvl_q   <= flt_lvl_i;
      eaddr_q <= flt_addr_i;
    end else if (clr_i) begin
      flags_q <= '0;
      code_q  <= '0;
      lvl_q   <= '0;
      eaddr_q <= '0;
    end
  end

  assign ctrl_o  = ctrl_q | (32'(busy_q) << CTRL_FLUSH_B);
  assign stat_o  = {18'd0, lvl_q, 1'b0, code_q, 3'd0, flags_q[3], 1'b0, flags_q[2:0]};
  assign eaddr_o = eaddr_q;
  assign en_o    = ctrl_q[CTRL_EN_B];
  assign inten_o = ctrl_q[CTRL_INTEN_B];
  assign flush_o = flush_q;
  assign busy_o  = busy_q;
  assign fault_o = |flags_q;
endmodule

// File: rtl/iommu_irq_merge.sv
module iommu_irq_merge #(
  parameter int unsigned NUM_CTX = 4
) (
  input  logic [NUM_CTX-1:0] inten_i,
  input  logic [NUM_CTX-1:0] fault_i,
  output logic               irq_o
);
  assign irq_o = |(inten_i & fault_i);
endmodule

// File: rtl/iommu_ctx_bank.sv
module iommu_ctx_bank
  import iommu_bank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned NUM_CTX    = 4,
  parameter int unsigned CTX_STRIDE = 64,
  parameter logic [ADDR_W-1:0] ALIAS_OFF = 12'h800,
  localparam int unsigned CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic               flt_valid_i,
  input  logic [CTX_W-1:0]   flt_ctx_i,
  input  logic [3:0]         flt_kind_i,
  input  logic [2:0]         flt_code_i,
  input  logic [1:0]         flt_lvl_i,
  input  logic [31:0]        flt_addr_i,
  input  logic [NUM_CTX-1:0] flush_done_i,
  output logic [NUM_CTX-1:0] ctx_en_o,
  output logic [NUM_CTX-1:0] irq_en_o,
  output logic [NUM_CTX-1:0] flush_o,
  output logic               irq_o
);
  reg_sel_e         sel;
  logic [CTX_W-1:0] ctx;

  logic [31:0] ctrl_rd  [NUM_CTX];
  logic [31:0] stat_rd  [NUM_CTX];
  logic [31:0] eaddr_rd [NUM_CTX];
  logic [NUM_CTX-1:0] busy_v, fault_v, clr_v;
  logic [NUM_CTX*32-1:0] eaddr_flat;
  logic [31:0] rd_val, rdata_q;

  iommu_bank_decode #(
    .ADDR_W(ADDR_W), .NUM_CTX(NUM_CTX), .CTX_STRIDE(CTX_STRIDE), .ALIAS_OFF(ALIAS_OFF)
  ) u_dec (
    .addr_i(addr_i), .sel_o(sel), .ctx_o(ctx)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic hit;
    assign hit      = req_i & we_i & (ctx == CTX_W'(c));
    assign clr_v[c] = hit & (sel == SEL_STAT) & (wdata_i == 32'd0);
    assign eaddr_flat[c*32 +: 32] = eaddr_rd[c];

    iommu_ctx_slot u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ctrl_we_i    (hit & (sel == SEL_CTRL)),
      .clr_i        (clr_v[c]),
      .wdata_i      (wdata_i),
      .flt_cap_i    (flt_valid_i & (flt_ctx_i == CTX_W'(c))),
      .flt_kind_i   (flt_kind_i),
      .flt_code_i   (flt_code_i),
      .flt_lvl_i    (flt_lvl_i),
      .flt_addr_i   (flt_addr_i),
      .flush_done_i (flush_done_i[c]),
      .ctrl_o       (ctrl_rd[c]),
      .stat_o       (stat_rd[c]),
      .eaddr_o      (eaddr_rd[c]),
      .en_o         (ctx_en_o[c]),
      .inten_o      (irq_en_o[c]),
      .flush_o      (flush_o[c]),
      .busy_o       (busy_v[c]),
      .fault_o      (fault_v[c])
    );
  end

  iommu_irq_merge #(.NUM_CTX(NUM_CTX)) u_irq (
    .inten_i(irq_en_o), .fault_i(fault_v), .irq_o(irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL:  rd_val = ctrl_rd[ctx];
      SEL_STAT:  rd_val = stat_rd[ctx];
      SEL_EADDR: rd_val = eaddr_rd[ctx];
      default:   rd_val = 32'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/iommu_ctx_bank_chk.sv
module iommu_ctx_bank_chk #(
  parameter int unsigned NUM_CTX = 4,
  parameter int unsigned CTX_W   = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_CTX-1:0]    flush_o,
  input logic [NUM_CTX-1:0]    busy_v,
  input logic [NUM_CTX-1:0]    fault_v,
  input logic [NUM_CTX-1:0]    clr_v,
  input logic [NUM_CTX-1:0]    irq_en_o,
  input logic                  irq_o,
  input logic                  flt_valid_i,
  input logic [CTX_W-1:0]      flt_ctx_i,
  input logic [NUM_CTX*32-1:0] eaddr_flat
);
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_p
    // R3: a strobe is always accompanied by a busy flag
    a_r3_flush_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o[c] |-> busy_v[c]);
    // R6: a held fault keeps its address unless acknowledged
    a_r6_addr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_v[c] && !clr_v[c]) |=> $stable(eaddr_flat[c*32 +: 32]));
    // R7: a clear with no competing report wipes the address
    a_r7_clear_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_v[c] && !(flt_valid_i && flt_ctx_i == CTX_W'(c))) |=> eaddr_flat[c*32 +: 32] == 32'd0);
  end
  // R8: interrupt needs an enabled context and a pending fault
  a_r8_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|irq_en_o));
  a_r8_needs_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|fault_v));
endmodule

bind iommu_ctx_bank iommu_ctx_bank_chk #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_o(flush_o), .busy_v(busy_v),
  .fault_v(fault_v), .clr_v(clr_v), .irq_en_o(irq_en_o), .irq_o(irq_o),
  .flt_valid_i(flt_valid_i), .flt_ctx_i(flt_ctx_i), .eaddr_flat(eaddr_flat)
);

// File: tb/tb_iommu_ctx_bank.sv
module tb_iommu_ctx_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic flt_valid = 0;
  logic [1:0] flt_ctx = '0;
  logic [3:0] flt_kind = '0;
  logic [2:0] flt_code = '0;
  logic [1:0] flt_lvl = '0;
  logic [31:0] flt_addr = '0;
  logic [3:0] flush_done = '0;
  logic [3:0] ctx_en, irq_en, flush;
  logic irq;

  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  iommu_ctx_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .flt_valid_i(flt_valid), .flt_ctx_i(flt_ctx),
    .flt_kind_i(flt_kind), .flt_code_i(flt_code), .flt_lvl_i(flt_lvl),
    .flt_addr_i(flt_addr), .flush_done_i(flush_done), .ctx_en_o(ctx_en),
    .irq_en_o(irq_en), .flush_o(flush), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic fault(input logic [1:0] c, input logic [3:0] k, input logic [2:0] cd,
                       input logic [1:0] lv, input logic [31:0] a);
    @(negedge clk); flt_valid = 1; flt_ctx = c; flt_kind = k; flt_code = cd; flt_lvl = lv; flt_addr = a;
    @(negedge clk); flt_valid = 0;
  endtask

  typedef struct packed {
    logic        we;
    logic [11:0] a;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  // writes carry data, reads carry the expected value
  localparam vec_t VECS [12] = '{
    '{1'b1, 12'h000, 32'hFFFF_FFFD, 4'd2},
    '{1'b0, 12'h000, 32'h0003_003D, 4'd2},   // R2 mask
    '{1'b0, 12'h800, 32'h0003_003D, 4'd4},   // R4 alias
    '{1'b1, 12'h840, 32'h0000_0011, 4'd4},
    '{1'b0, 12'h040, 32'h0000_0011, 4'd4},   // R4 window 1
    '{1'b0, 12'h080, 32'h0000_0000, 4'd4},
    '{1'b1, 12'h100, 32'h0000_DEAD, 4'd9},
    '{1'b0, 12'h100, 32'h0000_0000, 4'd9},   // R9 beyond last context
    '{1'b0, 12'h004, 32'h0000_0000, 4'd9},   // R9 hole
    '{1'b1, 12'h0C0, 32'h0000_0005, 4'd4},
    '{1'b0, 12'h8C0, 32'h0000_0005, 4'd4},
    '{1'b1, 12'h020, 32'h0000_1234, 4'd7}    // R7 nonzero write, read below
  };

  logic [31:0] v;

  initial begin
    #4000000;
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outputs", {ctx_en, irq_en, flush, 3'b0, irq}, 16'h0);
    check("R1 rdata", rdata, 32'h0);
    rst_n = 1;
    for (int c = 0; c < 4; c++) begin
      rd(12'(c * 64), v);      check("R1 ctrl", v, 0);
      rd(12'(c * 64 + 32), v); check("R1 stat", v, 0);
      rd(12'(c * 64 + 48), v); check("R1 eaddr", v, 0);
    end

    for (int i = 0; i < 12; i++) begin
      if (VECS[i].we) wr(VECS[i].a, VECS[i].d);
      else begin
        rd(VECS[i].a, v);
        check($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].d);
      end
    end
    rd(12'h020, v); check("R7 nonzero status write ignored", v, 0);
    // R10 read data held with no request, and appears one cycle after request
    check("R10 rdata latency", rdata, 0);

    // R2 control outputs
    check("R2 ctx_en", 32'(ctx_en), 32'b1011);
    check("R2 irq_en", 32'(irq_en), 32'b1001);

    // R3 flush strobe and busy
    wr(12'h080, 32'h7);
    check("R3 strobe high", 32'(flush), 32'b0100);
    @(negedge clk);
    check("R3 strobe one cycle", 32'(flush), 0);
    rd(12'h080, v); check("R3 busy", v, 32'h7);
    wr(12'h080, 32'h5);
    rd(12'h080, v); check("R3 busy not cancelled", v, 32'h7);
    @(negedge clk); flush_done = 4'b0100;
    @(negedge clk); flush_done = 0;
    rd(12'h080, v); check("R3 done clears", v, 32'h5);

    // R5 capture, R8 interrupt
    check("R8 idle", 32'(irq), 0);
    fault(2'd2, 4'b0010, 3'd4, 2'd2, 32'hCAFE_0000);
    check("R8 irq raised", 32'(irq), 1);
    rd(12'h0A0, v); check("R5 status", v, 32'h0000_2402);
    rd(12'h8B0, v); check("R5 eaddr", v, 32'hCAFE_0000);

    // R6 second report dropped
    fault(2'd2, 4'b0001, 3'd1, 2'd1, 32'h1111_1111);
    rd(12'h0A0, v); check("R6 status kept", v, 32'h0000_2402);
    rd(12'h0B0, v); check("R6 eaddr kept", v, 32'hCAFE_0000);

    // kind 0 is not captured
    fault(2'd0, 4'b0000, 3'd5, 2'd3, 32'h5555_0000);
    rd(12'h020, v); check("R5 empty kind", v, 0);

    // R8 masked context, R7 clear
    fault(2'd1, 4'b1000, 3'd1, 2'd1, 32'h0000_0042);
    rd(12'h060, v); check("R5 mhit status", v, 32'h0000_1110);
    wr(12'h0A0, 32'h0);
    check("R8 irq drops with masked ctx1 fault", 32'(irq), 0);
    rd(12'h0A0, v); check("R7 status cleared", v, 0);
    rd(12'h0B0, v); check("R7 eaddr cleared", v, 0);
    rd(12'h070, v); check("R7 other ctx kept", v, 32'h0000_0042);
    wr(12'h040, 32'h4);
    check("R8 irq on enable", 32'(irq), 1);
    wr(12'h860, 32'h0);
    check("R8 irq after ack", 32'(irq), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule